// File: doc/BRIEF.md
# Masked Interrupt Flag Controller

This block collects interrupt requests from two sources, a timer overflow pulse and an external active-low interrupt pin, and keeps one pending flag for each. A per-source enable mask and a single global enable decide whether a pending flag turns into a request to the processor core. Software observes the pending flags through a status register whose read value is filtered by the mask. It also owns the mask register, and it can acknowledge a source by clearing its flag.

The external pin is asynchronous. It passes through a two-flop synchronizer, and a falling edge on the synchronized level sets the external flag. The global enable follows the core's instruction stream. Enable and return-from-interrupt strobes set it. Disable strobes clear it, and so does the strobe the core raises when it takes an interrupt. Vector fetch and context save belong to the core and are not part of this block.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, the flags, the mask and the global enable are all 0. Reads of both registers return 0 and `irq_req_o` is low. Reset is asserted asynchronously and released through a two-flop synchronizer.
- R2: A falling edge on `ext_pin_i` sets status bit 3 on the third rising clock edge after the pin is sampled low. The pin passes two synchronizer flops before the edge detector. A pin held low, or a rising edge, sets nothing.
- R3: A one-cycle pulse on `tmr_ovf_i` sets status bit 0 at the next rising edge.
- R4: A write to the status register (`reg_sel_i`=0) clears each flag whose data bit is 0 and leaves a flag unchanged where the data bit is 1. A write never sets a flag.
- R5: If a hardware set and a software clear hit the same flag in one cycle, the flag ends up set.
- R6: A status read returns the flags ANDed with the mask. Bits 1, 2 and 7:4 always read 0. A flag that is masked stays pending and appears once its mask bit is set.
- R7: The mask register (`reg_sel_i`=1) stores all 8 written bits and reads them back unchanged. Bit 3 enables the external source and bit 0 enables the timer source, both active high.
- R8: The global enable is set by `gie_on_i` or `reti_i` and cleared by `gie_off_i` or `irq_taken_i`. If a set and a clear arrive in the same cycle, the clear wins.
- R9: `irq_req_o` is high exactly when the global enable is 1 and some flag is 1 under its mask bit. A pulse on `irq_taken_i` drops the request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register (combinational) |
| gie_on_i | input | 1 | Enable-instruction strobe |
| gie_off_i | input | 1 | Disable-instruction strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_taken_i | input | 1 | Core has taken the interrupt |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous, falling edge active |
| irq_req_o | output | 1 | Interrupt request to the core |

## Verification
The bench drives a timer set and a status-write clear into the same cycle. A design that lets the clear win would drop the event and read 0 where 1 is expected. It writes all-ones and all-zeros to the status register with flags pending, and to the mask with flags pending. A design that let writes set flags, or that gated the flags themselves rather than the read value, would show phantom or lost bits once the mask is restored. The external edge is checked one cycle before and at the cycle it should land, with a long low level and a rising edge that must not retrigger, which catches a missing synchronizer stage or a level-sensitive detector. Simultaneous enable and disable strobes, and a take arriving with an enable, must leave the request low, which catches a reversed priority.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int REG_W   = 8;
  localparam int TMR_BIT = 0;
  localparam int EXT_BIT = 3;
  localparam logic [REG_W-1:0] IMPL_MASK =
    REG_W'((1 << EXT_BIT) | (1 << TMR_BIT));

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_pin_edge.sv
// Synchronizes an asynchronous active-low pin and flags its falling edge.
module irq_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              level;

  assign level = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= level;
    end
  end

  assign fall_o = prev_q & ~level;
endmodule

// File: rtl/irq_flag_bank.sv
// Pending flags: hardware set has priority over software clear.
module irq_flag_bank #(
  parameter int          W    = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;
  logic [W-1:0] flag_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      flag_d[i] = IMPL[i] & (set_i[i] | (flag_q[i] & ~clr_i[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_gie_ctrl.sv
// Global enable bit; any clear source outranks any set source.
module irq_gie_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic on_i,
  input  logic reti_i,
  input  logic off_i,
  input  logic taken_i,
  output logic gie_o
);
  logic gie_q;
  logic gie_d;
  logic do_clr;
  logic do_set;

  always_comb begin
    do_clr = off_i | taken_i;
    do_set = on_i | reti_i;
    gie_d  = gie_q;
    if (do_clr)      gie_d = 1'b0;
    else if (do_set) gie_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else        gie_q <= gie_d;
  end

  assign gie_o = gie_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             gie_on_i,
  input  logic             gie_off_i,
  input  logic             reti_i,
  input  logic             irq_taken_i,
  input  logic             tmr_ovf_i,
  input  logic             ext_pin_i,
  output logic             irq_req_o
);
  // reset: asserted asynchronously, released synchronously
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  // external edge
  logic ext_fall;

  irq_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_i  (ext_pin_i),
    .fall_o (ext_fall)
  );

  // register decode
  reg_sel_e   sel;
  logic       status_we;
  logic       mask_we;
  logic [REG_W-1:0] hw_set;
  logic [REG_W-1:0] sw_clr;
  logic [REG_W-1:0] flag_q;
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] masked;

  always_comb begin
    sel       = reg_sel_e'(reg_sel_i);
    status_we = reg_wr_i & (sel == SEL_STATUS);
    mask_we   = reg_wr_i & (sel == SEL_MASK);
    hw_set          = '0;
    hw_set[TMR_BIT] = tmr_ovf_i;
    hw_set[EXT_BIT] = ext_fall;
    sw_clr    = {REG_W{status_we}} & ~reg_wdata_i;
  end

  irq_flag_bank #(.W(REG_W), .IMPL(IMPL_MASK)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (hw_set),
    .clr_i  (sw_clr),
    .flag_o (flag_q)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mask_q <= '0;
    else if (mask_we) mask_q <= reg_wdata_i;
  end

  // global enable
  logic gie_q;

  irq_gie_ctrl u_gie (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .on_i    (gie_on_i),
    .reti_i  (reti_i),
    .off_i   (gie_off_i),
    .taken_i (irq_taken_i),
    .gie_o   (gie_q)
  );

  // outputs
  assign masked      = flag_q & mask_q;
  assign reg_rdata_o = (sel == SEL_MASK) ? mask_q : masked;
  assign irq_req_o   = gie_q & (|masked);
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
  import irq_flag_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_sel_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             gie_on_i,
  input logic             gie_off_i,
  input logic             reti_i,
  input logic             irq_taken_i,
  input logic             tmr_ovf_i,
  input logic             irq_req_o,
  input logic             gie_q,
  input logic             ext_fall,
  input logic [REG_W-1:0] flag_q
);
  a_r3_tmr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf_i |=> flag_q[TMR_BIT]);

  a_r4_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q[TMR_BIT] && !tmr_ovf_i) |=> !flag_q[TMR_BIT]);

  a_r2_ext_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q[EXT_BIT] && !ext_fall) |=> !flag_q[EXT_BIT]);

  a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel_i == SEL_STATUS) |-> ((reg_rdata_o & ~IMPL_MASK) == '0));

  a_r8_gie_on: assert property (@(posedge clk) disable iff (!rst_n)
    ((gie_on_i || reti_i) && !gie_off_i && !irq_taken_i) |=> gie_q);

  a_r8_gie_off: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_off_i || irq_taken_i) |=> !gie_q);

  a_r9_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> gie_q);

  a_r9_taken_drops: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken_i |=> !irq_req_o);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .reg_sel_i   (reg_sel_i),
  .reg_rdata_o (reg_rdata_o),
  .gie_on_i    (gie_on_i),
  .gie_off_i   (gie_off_i),
  .reti_i      (reti_i),
  .irq_taken_i (irq_taken_i),
  .tmr_ovf_i   (tmr_ovf_i),
  .irq_req_o   (irq_req_o),
  .gie_q       (gie_q),
  .ext_fall    (ext_fall),
  .flag_q      (flag_q)
);

// File: tb/irq_flag_ctrl_bench.sv
`timescale 1ns/1ps
module irq_flag_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       gie_on = 1'b0, gie_off = 1'b0, reti = 1'b0, taken = 1'b0;
  logic       tmr_ovf = 1'b0, ext_pin = 1'b1;
  logic       irq_req;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .gie_on_i(gie_on), .gie_off_i(gie_off), .reti_i(reti),
    .irq_taken_i(taken), .tmr_ovf_i(tmr_ovf), .ext_pin_i(ext_pin),
    .irq_req_o(irq_req)
  );

  // {ovf, wr, wsel, gie_on, rsel, wdata[7:0], exp_rdata[7:0], exp_irq}
  localparam logic [21:0] VEC [0:9] = '{
    {1'b0,1'b1,1'b1,1'b0,1'b1,8'h09,8'h09,1'b0},
    {1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,8'h01,1'b0},
    {1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,8'h01,1'b1},
    {1'b0,1'b1,1'b0,1'b0,1'b0,8'hFF,8'h01,1'b1},
    {1'b0,1'b1,1'b0,1'b0,1'b0,8'hFE,8'h00,1'b0},
    {1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'h01,1'b1},
    {1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,8'h00,1'b0},
    {1'b0,1'b1,1'b1,1'b0,1'b1,8'hFF,8'hFF,1'b1},
    {1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h01,1'b1},
    {1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive at a negedge, let one rising edge pass, release strobes at next negedge
  task automatic step(input logic ovf, input logic wr, input logic wsel,
                      input logic [7:0] wd, input logic on, input logic off,
                      input logic rt, input logic tk, input logic rsel);
    tmr_ovf = ovf; reg_wr = wr; reg_sel = wsel; reg_wdata = wd;
    gie_on = on; gie_off = off; reti = rt; taken = tk;
    @(negedge clk);
    tmr_ovf = 1'b0; reg_wr = 1'b0; gie_on = 1'b0; gie_off = 1'b0;
    reti = 1'b0; taken = 1'b0; reg_sel = rsel;
    #1;
  endtask

  task automatic idle(input int n, input logic rsel);
    for (int i = 0; i < n; i++) step(1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,rsel);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reg_sel = 1'b0; #1;
    check("R1 status after reset", reg_rdata, 8'h00);
    check("R1 irq after reset", {7'b0, irq_req}, 8'h00);
    reg_sel = 1'b1; #1;
    check("R1 mask after reset", reg_rdata, 8'h00);
    @(negedge clk);

    // table: R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < 10; v++) begin
      logic [21:0] e;
      e = VEC[v];
      step(e[21], e[20], e[19], e[16:9], e[18], 1'b0, 1'b0, 1'b0, e[17]);
      check($sformatf("R3/R4/R5/R6/R7 table vec %0d rdata", v), reg_rdata, e[8:1]);
      check($sformatf("R9 table vec %0d irq", v), {7'b0, irq_req}, {7'b0, e[0]});
    end

    // R2: falling edge on the pin, two sync flops then detect (mask=FF, gie=1)
    ext_pin = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    check("R2 ext not yet set", reg_rdata, 8'h00);
    @(negedge clk); #1;
    check("R2 ext flag set on third edge", reg_rdata, 8'h08);
    check("R9 irq from ext flag", {7'b0, irq_req}, 8'h01);
    step(1'b0,1'b1,1'b0,8'hF7,1'b0,1'b0,1'b0,1'b0,1'b0);
    check("R4 ext flag cleared by 0 bit", reg_rdata, 8'h00);
    idle(4, 1'b0);
    check("R2 steady low does not retrigger", reg_rdata, 8'h00);
    ext_pin = 1'b1;
    idle(4, 1'b0);
    check("R2 rising edge sets nothing", reg_rdata, 8'h00);

    // R8 / R9: global enable handling
    step(1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0);
    check("R9 timer flag raises request", {7'b0, irq_req}, 8'h01);
    step(1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0);
    check("R9 taken drops request", {7'b0, irq_req}, 8'h00);
    check("R6 flag still pending after take", reg_rdata, 8'h01);
    step(1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0);
    check("R8 reti re-enables", {7'b0, irq_req}, 8'h01);
    step(1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0);
    check("R8 disable clears", {7'b0, irq_req}, 8'h00);
    step(1'b0,1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,1'b0);
    check("R8 enable with disable: clear wins", {7'b0, irq_req}, 8'h00);
    step(1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0);
    check("R8 enable sets", {7'b0, irq_req}, 8'h01);
    step(1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1,1'b0);
    check("R8 take with enable: clear wins", {7'b0, irq_req}, 8'h00);

    // R1: asynchronous reset in mid-run
    rst_n = 1'b0; reg_sel = 1'b0; #1;
    check("R1 async reset clears status", reg_rdata, 8'h00);
    check("R1 async reset clears irq", {7'b0, irq_req}, 8'h00);
    reg_sel = 1'b1; #1;
    check("R1 async reset clears mask", reg_rdata, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule